// File: doc/BRIEF.md
# E1 Timeslot Zero Frame Aligner

The block takes a 2.048 Mbit/s serial E1 stream, one bit per clock, and finds where its frames begin. It hunts for the frame alignment word that sync frames carry in timeslot zero. It confirms a candidate with the bit that marks the following non-sync frame, and then with the word in the frame after that. Once locked, it keeps watching the alignment word in every sync frame. It drops lock after a run of errored words.

While locked, it drives a set of timing markers for the rest of the receive path: a timeslot-zero window, a marker that flags sync frames, an 8 kHz clock and an active-low channel reset pulse. While unlocked, all markers sit at their inactive levels. A synchronous resync input throws away any lock and restarts the hunt.

Top module: `e1_ts0_aligner`

## Requirements
- R1: After the asynchronous reset, or in the cycle after resync_i is sampled high, aligned_o is 0 and the hunt restarts. While aligned_o is 0 the markers are inactive: ts0_win_o=0, sync_mark_o=0, clk8k_o=1, chan_rst_n_o=1.
- R2: Frame positions are numbered 0..255 from the first bit of timeslot 0, and bit k of timeslot t sits at position 8t+k-1. Lock requires three checks in order. First, bits 2..8 of timeslot 0 equal 0011011, first bit sent first. Second, bit 2 of timeslot 0 in the next frame is 1. Third, the word is correct again in the frame after that. aligned_o rises at bit 1 of timeslot 1 of that last frame.
- R3: If the non-sync bit check or the confirming word check fails during acquisition, the attempt is dropped. The search resumes with the following bit, and the next correct word starts a new attempt.
- R4: While locked, lock is lost after three consecutive errored alignment words, and aligned_o falls at bit 1 of timeslot 1 of the third. A correct word clears the error run, so two errors followed by a good word keep the lock.
- R5: ts0_win_o is 1 for exactly the 8 bit positions 0..7 of every frame while locked.
- R6: sync_mark_o is 1 during timeslot 0 of sync frames. It changes only at bit 2 of timeslot 1 (position 9), taking the sync status of the following frame.
- R7: clk8k_o goes low at position 7, after bit 7 of timeslot 0. It goes high at position 135, after bit 7 of timeslot 16.
- R8: chan_rst_n_o is 0 for the single position 8 (bit 1 of timeslot 1) of sync frames only.
- R9: While locked, bit 2 of timeslot 0 in non-sync frames is ignored: a 0 there changes neither the lock nor any marker.
- R10: A frame is 256 bit periods and sync and non-sync frames alternate, so all markers repeat every 512 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Synchronous request to drop lock and restart the hunt |
| data_i | input | 1 | Serial E1 data |
| aligned_o | output | 1 | High while frame alignment is held |
| ts0_win_o | output | 1 | Timeslot-zero window |
| sync_mark_o | output | 1 | Sync frame marker |
| clk8k_o | output | 1 | 8 kHz frame clock |
| chan_rst_n_o | output | 1 | Active-low channel reset pulse |

## Verification
The hardest states to reach are the single failure points inside acquisition and the exact length of the error run that ends lock. Each needs a specific frame to be corrupted while the aligner is in one particular internal phase. The stimulus fills every payload bit with ones, so the alignment pattern can only appear where it is placed on purpose. It then corrupts chosen frames by index: a zeroed non-sync bit right after the first word, a blanked confirming word, two errored words followed by a good one, three errored words in a row, and a zeroed non-sync bit while locked. The stream starts at a random bit offset and ends with a resync in mid-frame. A behavioural model in the bench follows these frame indices to predict the lock state and every marker level for each bit.

// File: rtl/e1_ts0_pkg.sv
`timescale 1ns/1ps
package e1_ts0_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_NFAS    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_LOCKED  = 2'd3
  } align_st_e;
endpackage

// File: rtl/e1_bit_timer.sv
`timescale 1ns/1ps
module e1_bit_timer #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 8,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  output logic [PW-1:0] pos_o,
  output logic          sync_fr_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] LPOS = PW'(LOAD_POS);

  logic [PW-1:0] pos_q;
  logic          sync_fr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      sync_fr_q <= 1'b0;
    end else if (load_i) begin
      pos_q     <= LPOS;
      sync_fr_q <= 1'b1;
    end else if (pos_q == LAST) begin
      pos_q     <= '0;
      sync_fr_q <= ~sync_fr_q;
    end else begin
      pos_q <= pos_q + PW'(1);
    end
  end

  assign pos_o     = pos_q;
  assign sync_fr_o = sync_fr_q;

  assert_frame_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == LAST && !load_i) |=> (pos_q == '0 && sync_fr_q != $past(sync_fr_q)));

  assert_load_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_q == LPOS && sync_fr_q));
endmodule

// File: rtl/e1_faw_detect.sv
`timescale 1ns/1ps
module e1_faw_detect #(
  parameter int               FAW_LEN = 7,
  parameter logic [FAW_LEN-1:0] FAW   = 7'b0011011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic match_o
);
  // oldest bit in the MSB, the bit on data_i completes the word
  logic [FAW_LEN-2:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[FAW_LEN-3:0], data_i};
  end

  assign match_o = ({hist_q, data_i} == FAW);
endmodule

// File: rtl/e1_align_fsm.sv
`timescale 1ns/1ps
module e1_align_fsm
  import e1_ts0_pkg::*;
#(
  parameter int PW         = 8,
  parameter int FAW_END    = 7,
  parameter int NFAS_POS   = 1,
  parameter int LOSS_LIMIT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          resync_i,
  input  logic          data_i,
  input  logic          match_i,
  input  logic [PW-1:0] pos_i,
  input  logic          sync_fr_i,
  output logic          load_o,
  output logic          aligned_o
);
  localparam int            EW       = $clog2(LOSS_LIMIT + 1);
  localparam logic [EW-1:0] ERR_LAST = EW'(LOSS_LIMIT - 1);
  localparam logic [PW-1:0] FAW_P    = PW'(FAW_END);
  localparam logic [PW-1:0] NFAS_P   = PW'(NFAS_POS);

  align_st_e     st_q, st_d;
  logic [EW-1:0] err_q, err_d;
  logic          faw_slot, nfas_slot;

  assign faw_slot  = (pos_i == FAW_P) && sync_fr_i;
  assign nfas_slot = (pos_i == NFAS_P) && !sync_fr_i;

  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (match_i) begin
          load_o = 1'b1;
          st_d   = ST_NFAS;
        end
      end
      ST_NFAS: begin
        if (nfas_slot) st_d = data_i ? ST_CONFIRM : ST_HUNT;
      end
      ST_CONFIRM: begin
        if (faw_slot) begin
          st_d  = match_i ? ST_LOCKED : ST_HUNT;
          err_d = '0;
        end
      end
      ST_LOCKED: begin
        if (faw_slot) begin
          if (match_i) err_d = '0;
          else if (err_q == ERR_LAST) begin
            st_d  = ST_HUNT;
            err_d = '0;
          end else err_d = err_q + EW'(1);
        end
      end
    endcase
    if (resync_i) begin
      st_d   = ST_HUNT;
      err_d  = '0;
      load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign aligned_o = (st_q == ST_LOCKED);

  assert_resync_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !aligned_o);

  assert_lock_at_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> ($past(pos_i) == FAW_P && $past(sync_fr_i) && $past(match_i)));

  assert_loss_at_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(aligned_o) && !$past(resync_i)) |->
      ($past(pos_i) == FAW_P && $past(sync_fr_i) && !$past(match_i)));
endmodule

// File: rtl/e1_marker_gen.sv
`timescale 1ns/1ps
module e1_marker_gen #(
  parameter int PW      = 8,
  parameter int TS_BITS = 8,
  parameter int CK_LO   = 7,
  parameter int CK_HI   = 135
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          aligned_i,
  input  logic [PW-1:0] pos_i,
  input  logic          sync_fr_i,
  output logic          ts0_win_o,
  output logic          sync_mark_o,
  output logic          clk8k_o,
  output logic          chan_rst_n_o
);
  localparam logic [PW-1:0] TS1_B1 = PW'(TS_BITS);
  localparam logic [PW-1:0] LO_P   = PW'(CK_LO);
  localparam logic [PW-1:0] HI_P   = PW'(CK_HI);

  logic in_ts0, pre_flip, ck_low, rst_slot;

  assign in_ts0   = pos_i < TS1_B1;
  assign pre_flip = pos_i <= TS1_B1;   // marker flips at bit 2 of timeslot 1
  assign ck_low   = (pos_i >= LO_P) && (pos_i < HI_P);
  assign rst_slot = (pos_i == TS1_B1) && sync_fr_i;

  assign ts0_win_o    = aligned_i & in_ts0;
  assign sync_mark_o  = aligned_i & (pre_flip ? sync_fr_i : ~sync_fr_i);
  assign clk8k_o      = ~(aligned_i & ck_low);
  assign chan_rst_n_o = ~(aligned_i & rst_slot);

  assert_chan_rst_ctx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_rst_n_o |-> (aligned_i && !ts0_win_o && sync_mark_o));

  assert_ck8_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk8k_o) && $past(aligned_i)) |-> ts0_win_o);

  assert_sync_mark_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_mark_o) && $past(aligned_i)) |-> !ts0_win_o);
endmodule

// File: rtl/e1_ts0_aligner.sv
`timescale 1ns/1ps
module e1_ts0_aligner #(
  parameter int                 TS_BITS    = 8,
  parameter int                 NUM_TS     = 32,
  parameter int                 FAW_LEN    = 7,
  parameter logic [FAW_LEN-1:0] FAW        = 7'b0011011,
  parameter int                 LOSS_LIMIT = 3,
  parameter int                 CK_TS      = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resync_i,
  input  logic data_i,
  output logic aligned_o,
  output logic ts0_win_o,
  output logic sync_mark_o,
  output logic clk8k_o,
  output logic chan_rst_n_o
);
  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int FAW_END    = TS_BITS - 1;
  localparam int NFAS_POS   = TS_BITS - FAW_LEN;
  localparam int CK_LO      = TS_BITS - 1;
  localparam int CK_HI      = CK_TS * TS_BITS + TS_BITS - 1;

  logic [PW-1:0] pos;
  logic          sync_fr, match, load;

  e1_bit_timer #(.FRAME_BITS(FRAME_BITS), .LOAD_POS(TS_BITS), .PW(PW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .pos_o(pos), .sync_fr_o(sync_fr)
  );

  e1_faw_detect #(.FAW_LEN(FAW_LEN), .FAW(FAW)) u_detect (
    .clk_i, .rst_ni, .data_i, .match_o(match)
  );

  e1_align_fsm #(.PW(PW), .FAW_END(FAW_END), .NFAS_POS(NFAS_POS),
                 .LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
    .clk_i, .rst_ni, .resync_i, .data_i, .match_i(match), .pos_i(pos),
    .sync_fr_i(sync_fr), .load_o(load), .aligned_o
  );

  e1_marker_gen #(.PW(PW), .TS_BITS(TS_BITS), .CK_LO(CK_LO), .CK_HI(CK_HI)) u_marks (
    .clk_i, .rst_ni, .aligned_i(aligned_o), .pos_i(pos), .sync_fr_i(sync_fr),
    .ts0_win_o, .sync_mark_o, .clk8k_o, .chan_rst_n_o
  );
endmodule

// File: tb/e1_ts0_aligner_test.sv
`timescale 1ns/1ps
module e1_ts0_aligner_test;
  localparam int NFR = 45;

  logic clk = 1'b0;
  logic rst_ni, resync_i, data_i;
  logic aligned_o, ts0_win_o, sync_mark_o, clk8k_o, chan_rst_n_o;
  int   total = 0, bad = 0;
  bit   done = 0;
  string ptag;

  always #2 clk = ~clk;

  e1_ts0_aligner uut (
    .clk_i(clk), .rst_ni, .resync_i, .data_i,
    .aligned_o, .ts0_win_o, .sync_mark_o, .clk8k_o, .chan_rst_n_o
  );

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit faw_bad(int g);
    return g == 6 || g == 14 || g == 16 || g == 22 || g == 24 || g == 26;
  endfunction

  function automatic bit b2_bad(int g);
    return g == 3 || g == 33;
  endfunction

  // payload all ones so the word only appears where placed
  function automatic logic gen_bit(int g, int p);
    logic [6:0] w;
    w = 7'b0011011;
    if (p >= 8) return 1'b1;
    if (g % 2 == 0) begin
      if (p == 0 || faw_bad(g)) return 1'b1;
      return w[7-p];
    end
    if (p == 1 && b2_bad(g)) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int start;
    bit a;
    int cnt, err;
    a = 0; cnt = 0; err = 0;
    rst_ni = 1'b0; resync_i = 1'b0; data_i = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset aligned_o", aligned_o, 1'b0);
    chk("R1 reset ts0_win_o", ts0_win_o, 1'b0);
    chk("R1 reset sync_mark_o", sync_mark_o, 1'b0);
    chk("R1 reset clk8k_o", clk8k_o, 1'b1);
    chk("R1 reset chan_rst_n_o", chan_rst_n_o, 1'b1);
    @(negedge clk) rst_ni = 1'b1;
    start = 8 + $urandom_range(503);
    for (int n = start; n < NFR * 256; n++) begin
      int  g = n / 256;
      int  p = n % 256;
      bit  s = (g % 2 == 0);
      bit  rs;
      rs = (g == 36 && p == 100);
      @(negedge clk);
      data_i   = gen_bit(g, p);
      resync_i = rs;
      if (g < 12)      ptag = "R2 R3";
      else if (g < 28) ptag = "R4";
      else if (g < 35) ptag = "R9";
      else             ptag = "R1";
      #1;
      chk({"aligned_o ", ptag}, aligned_o, a);
      chk("ts0_win_o R5 R10", ts0_win_o, a && p < 8);
      chk("sync_mark_o R6", sync_mark_o, a && (p <= 8 ? s : !s));
      chk("clk8k_o R7", clk8k_o, !(a && p >= 7 && p <= 134));
      chk("chan_rst_n_o R8", chan_rst_n_o, !(a && s && p == 8));
      // reference model update on the bit just driven
      if (rs) begin
        a = 0; cnt = 0; err = 0;
      end else if (s && p == 7) begin
        if (!a) begin
          if (!faw_bad(g)) begin
            cnt++;
            if (cnt == 2) begin a = 1; err = 0; end
          end else cnt = 0;
        end else begin
          if (!faw_bad(g)) err = 0;
          else begin
            err++;
            if (err == 3) begin a = 0; cnt = 0; err = 0; end
          end
        end
      end else if (!s && p == 1 && !a && cnt == 1 && b2_bad(g)) begin
        cnt = 0;
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule